// File: doc/BRIEF.md
# Gated IF Frequency Counter

This block measures the frequency of an intermediate-frequency signal by counting its rising edges over a gate time. The gate time is derived from a 1 kHz time-base tick. A level-sensitive start bit controls the measurement. While the bit is 0 the counter and the done flag are held cleared. When the bit goes from 0 to 1, a settling wait runs first, and the gated count follows it.

The gate-time selector is sampled when the start bit rises. It picks one of four gate lengths, and the settling wait is tied to that choice: the two short gates get a short wait and the two long gates a long one. At the end of the gate a done flag rises. The result then stays frozen and readable for as long as the start bit remains 1. A pulse on the access-event input, which marks any new control-port transfer, drops the done flag and leaves the result in place. An inhibit input pauses the time base and the edge counting without losing the state. Frequency is the count divided by the gate time: for example, 3600 edges in an 8 ms gate means 450 kHz.

Top module: `fc_gated_counter`

## Requirements
- R1: After reset, count_o is 0, done_o is 0 and busy_o is 0.
- R2: While start is 0, count_o is 0, done_o is 0 and busy_o is 0 from the next clock onward, whatever the earlier state was.
- R3: A 0-to-1 change of start makes busy_o 1 on the next clock and begins a settling wait. The wait lasts 4 ticks for gate_sel 00 or 01 and 8 ticks for gate_sel 10 or 11. Edges on if_in during the wait are not counted.
- R4: The gate opens on the tick that ends the wait. The gate lasts 4, 8, 32 or 64 ticks for gate_sel 00, 01, 10 and 11 respectively. Each rising edge of if_in inside the gate adds one to count_o.
- R5: On the tick that ends the gate, done_o becomes 1 and busy_o becomes 0. From then on, count_o does not change while start stays 1, even when if_in keeps toggling.
- R6: A one-cycle pulse on access_evt after the gate has ended clears done_o and leaves count_o unchanged.
- R7: While inhibit is 1, ticks do not advance the wait or the gate, and if_in edges are not counted. When inhibit returns to 0, timing resumes from where it paused.
- R8: count_o saturates at its all-ones value and does not wrap to 0.
- R9: gate_sel is sampled only when start rises. A change to gate_sel during a measurement does not alter that measurement's wait or gate length.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| if_in | input | 1 | Signal being measured, asynchronous to clk |
| tick_1k | input | 1 | One-cycle time-base pulse, nominally every 1 ms |
| start | input | 1 | Measurement control level; 0 clears, a rising edge starts a measurement |
| gate_sel | input | 2 | Gate-time code: 00=4, 01=8, 10=32, 11=64 ticks |
| inhibit | input | 1 | Pauses the timing and the counting while 1 |
| access_evt | input | 1 | One-cycle pulse marking a control-port transfer; clears done |
| count_o | output | CNT_W (20) | Edge count of the latest measurement |
| done_o | output | 1 | Measurement finished |
| busy_o | output | 1 | Wait or gate in progress |

## Verification
The bench places edges on if_in just before and just after the last wait tick. A design whose wait is too long for the chosen code misses gate edges, and one whose wait is too short counts edges that should be ignored. Each code has a check one tick before the gate should close, so an off-by-one gate length shows up as an early done_o or as a wrong count. Other scenarios cover the remaining corner cases:
- gate_sel changes in mid-measurement; a design that reads the code live closes the gate at the wrong tick.
- ticks arrive during inhibit; a design that does not freeze its timer ends the gate early.
- a narrow counter instance sees more edges than it can hold; a design without saturation wraps around.

// File: rtl/fc_pkg.sv
package fc_pkg;
   typedef enum logic [1:0] {
      FC_IDLE = 2'd0,
      FC_WAIT = 2'd1,
      FC_GATE = 2'd2,
      FC_HELD = 2'd3
   } fc_state_e;
endpackage

// File: rtl/fc_edge_sync.sv
module fc_edge_sync #(
   parameter int STAGES     = 2,
   parameter bit BOTH_EDGES = 1'b0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic sig_in,
   output logic edge_o
);
   localparam int MSB = STAGES - 1;

   logic [STAGES-1:0] shreg;
   logic              last_q;

   initial begin
      assert (STAGES >= 2) else $error("fc_edge_sync: STAGES must be at least 2");
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         shreg  <= '0;
         last_q <= 1'b0;
      end else begin
         shreg  <= {shreg[MSB-1:0], sig_in};
         last_q <= shreg[MSB];
      end
   end

   generate
      if (BOTH_EDGES) begin : g_both
         assign edge_o = shreg[MSB] ^ last_q;
      end else begin : g_rise
         assign edge_o = shreg[MSB] & ~last_q;
      end
   endgenerate
endmodule

// File: rtl/fc_sat_counter.sv
module fc_sat_counter #(
   parameter int W = 20
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         clr,
   input  logic         inc,
   output logic [W-1:0] q
);
   localparam logic [W-1:0] TOP = {W{1'b1}};

   initial begin
      assert (W >= 2) else $error("fc_sat_counter: W must be at least 2");
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                q <= '0;
      else if (clr)              q <= '0;
      else if (inc && q != TOP)  q <= q + 1'b1;
   end

   // R8: once full, the value stays full until cleared
   a_r8_no_wrap: assert property (@(posedge clk) disable iff (!rst_n)
      (q == TOP && !clr) |=> (q == TOP));
endmodule

// File: rtl/fc_gate_timer.sv
module fc_gate_timer
   import fc_pkg::*;
#(
   parameter int WAIT_SHORT = 4,
   parameter int WAIT_LONG  = 8,
   parameter int GATE_T0    = 4,
   parameter int GATE_T1    = 8,
   parameter int GATE_T2    = 32,
   parameter int GATE_T3    = 64
) (
   input  logic      clk,
   input  logic      rst_n,
   input  logic      arm,
   input  logic      abort,
   input  logic      tick,
   input  logic      freeze,
   input  logic [1:0] sel,
   output fc_state_e state_o,
   output logic      fin_o
);
   localparam int MAX_G01 = (GATE_T0 > GATE_T1) ? GATE_T0 : GATE_T1;
   localparam int MAX_G23 = (GATE_T2 > GATE_T3) ? GATE_T2 : GATE_T3;
   localparam int MAX_G   = (MAX_G01 > MAX_G23) ? MAX_G01 : MAX_G23;
   localparam int MAX_W   = (WAIT_SHORT > WAIT_LONG) ? WAIT_SHORT : WAIT_LONG;
   localparam int MAX_ALL = (MAX_G > MAX_W) ? MAX_G : MAX_W;
   localparam int TW      = $clog2(MAX_ALL + 1);

   fc_state_e     st;
   logic [TW-1:0] tc;
   logic [1:0]    sel_q;
   logic [TW-1:0] wait_len;
   logic [TW-1:0] gate_len;
   logic          step;

   initial begin
      assert (WAIT_SHORT >= 1 && WAIT_LONG >= 1)
         else $error("fc_gate_timer: wait lengths must be at least 1");
      assert (GATE_T0 >= 1 && GATE_T1 >= 1 && GATE_T2 >= 1 && GATE_T3 >= 1)
         else $error("fc_gate_timer: gate lengths must be at least 1");
   end

   always_comb begin
      wait_len = sel_q[1] ? TW'(WAIT_LONG) : TW'(WAIT_SHORT);
      case (sel_q)
         2'b00:   gate_len = TW'(GATE_T0);
         2'b01:   gate_len = TW'(GATE_T1);
         2'b10:   gate_len = TW'(GATE_T2);
         default: gate_len = TW'(GATE_T3);
      endcase
   end

   assign step = tick && !freeze && !abort && !arm;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st    <= FC_IDLE;
         tc    <= '0;
         sel_q <= 2'b00;
      end else if (abort) begin
         st <= FC_IDLE;
         tc <= '0;
      end else if (arm) begin
         st    <= FC_WAIT;
         tc    <= '0;
         sel_q <= sel;
      end else if (step) begin
         case (st)
            FC_WAIT: begin
               if (tc == wait_len - 1'b1) begin
                  st <= FC_GATE;
                  tc <= '0;
               end else begin
                  tc <= tc + 1'b1;
               end
            end
            FC_GATE: begin
               if (tc == gate_len - 1'b1) begin
                  st <= FC_HELD;
                  tc <= '0;
               end else begin
                  tc <= tc + 1'b1;
               end
            end
            default: tc <= '0;
         endcase
      end
   end

   assign state_o = st;
   assign fin_o   = step && (st == FC_GATE) && (tc == gate_len - 1'b1);

   // R3: the wait tick counter never passes its limit
   a_r3_wait_bound: assert property (@(posedge clk) disable iff (!rst_n)
      (st == FC_WAIT) |-> (tc < wait_len));
   // R4: the gate tick counter never passes its limit
   a_r4_gate_bound: assert property (@(posedge clk) disable iff (!rst_n)
      (st == FC_GATE) |-> (tc < gate_len));
   // R7: a frozen timer keeps its position
   a_r7_timer_frozen: assert property (@(posedge clk) disable iff (!rst_n)
      (freeze && !abort && !arm) |=> ($stable(tc) && $stable(st)));
endmodule

// File: rtl/fc_gated_counter.sv
module fc_gated_counter
   import fc_pkg::*;
#(
   parameter int CNT_W       = 20,
   parameter int SYNC_STAGES = 2,
   parameter bit BOTH_EDGES  = 1'b0,
   parameter int WAIT_SHORT  = 4,
   parameter int WAIT_LONG   = 8,
   parameter int GATE_T0     = 4,
   parameter int GATE_T1     = 8,
   parameter int GATE_T2     = 32,
   parameter int GATE_T3     = 64
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             if_in,
   input  logic             tick_1k,
   input  logic             start,
   input  logic [1:0]       gate_sel,
   input  logic             inhibit,
   input  logic             access_evt,
   output logic [CNT_W-1:0] count_o,
   output logic             done_o,
   output logic             busy_o
);
   logic      start_q;
   logic      arm;
   logic      abort;
   logic      edge_hit;
   logic      fin;
   logic      done_q;
   fc_state_e st;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) start_q <= 1'b0;
      else        start_q <= start;
   end

   assign arm   = start & ~start_q;
   assign abort = ~start;

   fc_edge_sync #(
      .STAGES     (SYNC_STAGES),
      .BOTH_EDGES (BOTH_EDGES)
   ) u_sync (
      .clk    (clk),
      .rst_n  (rst_n),
      .sig_in (if_in),
      .edge_o (edge_hit)
   );

   fc_gate_timer #(
      .WAIT_SHORT (WAIT_SHORT),
      .WAIT_LONG  (WAIT_LONG),
      .GATE_T0    (GATE_T0),
      .GATE_T1    (GATE_T1),
      .GATE_T2    (GATE_T2),
      .GATE_T3    (GATE_T3)
   ) u_timer (
      .clk     (clk),
      .rst_n   (rst_n),
      .arm     (arm),
      .abort   (abort),
      .tick    (tick_1k),
      .freeze  (inhibit),
      .sel     (gate_sel),
      .state_o (st),
      .fin_o   (fin)
   );

   fc_sat_counter #(
      .W (CNT_W)
   ) u_count (
      .clk   (clk),
      .rst_n (rst_n),
      .clr   (abort | arm),
      .inc   ((st == FC_GATE) & edge_hit & ~inhibit),
      .q     (count_o)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          done_q <= 1'b0;
      else if (abort)      done_q <= 1'b0;
      else if (arm)        done_q <= 1'b0;
      else if (fin)        done_q <= 1'b1;
      else if (access_evt) done_q <= 1'b0;
   end

   assign done_o = done_q;
   assign busy_o = (st == FC_WAIT) || (st == FC_GATE);

   // R2: a low start bit clears everything on the next clock
   a_r2_clear: assert property (@(posedge clk) disable iff (!rst_n)
      !start |=> (count_o == '0 && !done_o && !busy_o));
   // R3: nothing is counted during the settling wait
   a_r3_wait_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (st == FC_WAIT) |-> (count_o == '0));
   // R5: done and busy are never both high
   a_r5_done_not_busy: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |-> !busy_o);
   // R5: the result is frozen once the gate has closed
   a_r5_result_held: assert property (@(posedge clk) disable iff (!rst_n)
      (st == FC_HELD && start && start_q) |=> $stable(count_o));
   // R7: inhibit keeps the count still
   a_r7_no_count: assert property (@(posedge clk) disable iff (!rst_n)
      (inhibit && start && start_q) |=> $stable(count_o));
endmodule

// File: tb/fc_gated_counter_tb.sv
`timescale 1ns/1ps
module fc_gated_counter_tb;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        if_in = 1'b0;
   logic        tick_1k = 1'b0;
   logic        start = 1'b0;
   logic [1:0]  gate_sel = 2'b00;
   logic        inhibit = 1'b0;
   logic        access_evt = 1'b0;
   logic [19:0] count_o;
   logic        done_o;
   logic        busy_o;
   logic [3:0]  count_sat;
   logic        done_sat;
   logic        busy_sat;

   int n_chk = 0;
   int n_err = 0;
   bit finished = 1'b0;

   always #2 clk = ~clk;

   fc_gated_counter u_dut (
      .clk (clk), .rst_n (rst_n), .if_in (if_in), .tick_1k (tick_1k),
      .start (start), .gate_sel (gate_sel), .inhibit (inhibit),
      .access_evt (access_evt), .count_o (count_o), .done_o (done_o),
      .busy_o (busy_o)
   );

   fc_gated_counter #(.CNT_W (4)) u_dut_sat (
      .clk (clk), .rst_n (rst_n), .if_in (if_in), .tick_1k (tick_1k),
      .start (start), .gate_sel (gate_sel), .inhibit (inhibit),
      .access_evt (access_evt), .count_o (count_sat), .done_o (done_sat),
      .busy_o (busy_sat)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_err++;
         $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic tick();
      @(negedge clk) tick_1k = 1'b1;
      @(negedge clk) tick_1k = 1'b0;
   endtask

   task automatic ticks(input int n);
      for (int i = 0; i < n; i++) tick();
   endtask

   task automatic pulses(input int n);
      for (int i = 0; i < n; i++) begin
         @(negedge clk) if_in = 1'b1;
         repeat (3) @(negedge clk);
         if_in = 1'b0;
         repeat (3) @(negedge clk);
      end
   endtask

   function automatic int wait_of(input logic [1:0] c);
      return c[1] ? 8 : 4;
   endfunction

   function automatic int gate_of(input logic [1:0] c);
      case (c)
         2'b00:   return 4;
         2'b01:   return 8;
         2'b10:   return 32;
         default: return 64;
      endcase
   endfunction

   task automatic arm_with(input logic [1:0] c);
      @(negedge clk) start = 1'b0;
      gate_sel = c;
      @(negedge clk) start = 1'b1;
      @(negedge clk);
   endtask

   task automatic t_reset();
      chk("R1 count", count_o, 0);
      chk("R1 done", done_o, 0);
      chk("R1 busy", busy_o, 0);
   endtask

   task automatic t_measure(input logic [1:0] c, input int n);
      arm_with(c);
      chk("R3 busy after start", busy_o, 1);
      ticks(wait_of(c) - 1);
      pulses(2);
      chk("R3 no count in wait", count_o, 0);
      tick();
      pulses(n);
      ticks(gate_of(c) - 1);
      chk("R4 not done before last gate tick", done_o, 0);
      chk("R4 busy in gate", busy_o, 1);
      tick();
      chk("R5 done at gate end", done_o, 1);
      chk("R5 busy low at end", busy_o, 0);
      chk("R4 edge count", count_o, n);
      pulses(3);
      chk("R5 result held", count_o, n);
      @(negedge clk) access_evt = 1'b1;
      @(negedge clk) access_evt = 1'b0;
      chk("R6 done cleared", done_o, 0);
      chk("R6 count kept", count_o, n);
      start = 1'b0;
      @(negedge clk);
      chk("R2 count cleared", count_o, 0);
      chk("R2 idle", busy_o, 0);
   endtask

   task automatic t_clear_done();
      arm_with(2'b00);
      ticks(4);
      pulses(1);
      ticks(4);
      chk("R5 done before clear", done_o, 1);
      start = 1'b0;
      @(negedge clk);
      chk("R2 done cleared by start low", done_o, 0);
   endtask

   task automatic t_sel_change();
      arm_with(2'b00);
      gate_sel = 2'b11;
      ticks(4);
      pulses(2);
      ticks(3);
      chk("R9 not done early", done_o, 0);
      tick();
      chk("R9 latched gate length", done_o, 1);
      chk("R9 count", count_o, 2);
      @(negedge clk) start = 1'b0;
   endtask

   task automatic t_inhibit();
      arm_with(2'b00);
      ticks(4);
      pulses(2);
      tick();
      @(negedge clk) inhibit = 1'b1;
      pulses(3);
      ticks(2);
      chk("R7 no count while inhibited", count_o, 2);
      chk("R7 still busy", busy_o, 1);
      @(negedge clk) inhibit = 1'b0;
      pulses(1);
      ticks(2);
      chk("R7 timer paused, not done", done_o, 0);
      tick();
      chk("R7 done after resume", done_o, 1);
      chk("R7 count after resume", count_o, 3);
      @(negedge clk) start = 1'b0;
   endtask

   task automatic t_saturate();
      arm_with(2'b01);
      ticks(8);
      pulses(20);
      ticks(8);
      chk("R8 wide counter", count_o, 20);
      chk("R8 narrow counter saturates", count_sat, 15);
      chk("R8 narrow done", done_sat, 1);
      @(negedge clk) start = 1'b0;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!finished) begin
         n_chk++;
         n_err++;
         $display("FAIL watchdog: actual=timeout expected=completion");
         $display("Result: errors=%0d of %0d checks", n_err, n_chk);
         $finish;
      end
   end

   initial begin
      repeat (5) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_measure(2'b00, 5);
      t_measure(2'b01, 3);
      t_measure(2'b10, 7);
      t_measure(2'b11, 2);
      t_clear_done();
      t_sel_change();
      t_inhibit();
      t_saturate();
      repeat (3) @(negedge clk);
      finished = 1'b1;
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end
endmodule